// File: doc/BRIEF.md
# Tagged integer add/compare unit

This execution unit performs arithmetic on tagged machine words for dynamically typed language runtimes. The low bits of each word hold a type tag and the upper bits hold a two's-complement integer. Each instruction carries its own 6-bit tag specification. That specification gives the tag width, from one to four bits, and the tag value an operand must carry to count as a small integer.

When an operand has the wrong tag, or when the integer field overflows, the unit raises a skip strobe. The surrounding pipeline uses it to annul the next instruction, which is normally the branch over the slow generic path. A successful add, subtract or add-immediate returns a word whose tag is unchanged. Compare returns signed less-than and equal flags for the integer fields.

Inputs are sampled on a clock edge. The outputs, with a valid strobe, appear after that edge.

Top module: `tagged_alu`

## Requirements
- R1: The tag specification holds the size code in bits [5:4] and the required tag value in bits [3:0]. Size code n makes the low n+1 bits of every operand the tag.
- R2: Bits of the required tag value above the selected tag width do not affect matching or the result.
- R3: For add (opcode 00) and subtract (opcode 01), skip is 1 when either operand's tag differs from the required tag value.
- R4: For add, subtract and add-immediate, skip is 1 when the signed add or subtract of the integer fields does not fit in the integer field.
- R5: Compare (opcode 10) sets skip only on a tag mismatch of either operand, and never because of the operand magnitudes.
- R6: When skip is 0 for add, subtract or add-immediate, the integer field of the result is the signed sum or difference of the operands' integer fields, and the result's low tag-width bits equal the required tag value.
- R7: Add-immediate (opcode 11) sign-extends the 16-bit immediate, shifts it left by the tag width and adds it to operand A's integer field. Only operand A's tag is checked, and src_b has no effect.
- R8: When skip is 0 for compare, lt is 1 exactly when A's integer field is signed-less than B's, eq is 1 exactly when the two fields are equal, and lt and eq are never both 1.
- R9: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 otherwise. Reset clears out_valid.
- R10: The opcode encoding is 00 add, 01 subtract, 10 compare, 11 add-immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 2 | Operation select |
| tag_spec | input | 6 | Tag size code and required tag value |
| src_a | input | W | First tagged operand |
| src_b | input | W | Second tagged operand, unused by add-immediate |
| imm | input | IMM_W | Untagged immediate for add-immediate |
| out_valid | output | 1 | Outputs are meaningful |
| result | output | W | Tagged result word |
| lt | output | 1 | Compare: A less than B |
| eq | output | 1 | Compare: A equal to B |
| skip | output | 1 | Annul the next instruction |

## Verification
A tag mismatch and an overflow of the integer field can occur in the same operation. The bench provokes this by combining a wrongly tagged operand with integer fields at the edge of the signed range, and by drawing random operands at the range extremes with a random tag. A single skip pulse is the only correct response: both causes feed the same strobe, and any result value is then allowed. The bench also drives compare with the same extreme operands to confirm that magnitude alone never raises skip there.

// File: rtl/tagged_alu.sv
module tagged_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       opcode,
  input  logic [5:0]       tag_spec,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             lt,
  output logic             eq,
  output logic             skip
);
  localparam logic [1:0] OP_ADD = 2'b00, OP_SUB = 2'b01, OP_CMP = 2'b10, OP_ADDI = 2'b11;

  logic [2:0]   tag_w;
  logic [W-1:0] mask, pat, a_f, b_f, imm_x, sum;
  logic         a_ok, b_ok, is_sub, is_imm, ovf, nxt_skip;

  assign tag_w  = {1'b0, tag_spec[5:4]} + 3'd1;
  assign mask   = ~({W{1'b1}} << tag_w);
  assign pat    = {{(W-4){1'b0}}, tag_spec[3:0]} & mask;
  assign is_sub = (opcode == OP_SUB);
  assign is_imm = (opcode == OP_ADDI);

  assign imm_x  = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
  assign a_f    = src_a & ~mask;
  assign b_f    = is_imm ? (imm_x << tag_w) : (src_b & ~mask);
  assign sum    = is_sub ? (a_f - b_f) : (a_f + b_f);

  assign a_ok   = (src_a & mask) == pat;
  assign b_ok   = is_imm || ((src_b & mask) == pat);

  assign ovf    = (opcode != OP_CMP) &&
                  ((a_f[W-1] ^ b_f[W-1]) == is_sub) &&
                  (sum[W-1] != a_f[W-1]);

  assign nxt_skip = !a_ok || !b_ok || ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      lt        <= 1'b0;
      eq        <= 1'b0;
      skip      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        skip <= nxt_skip;
        if (opcode == OP_CMP) begin
          result <= '0;
          lt     <= $signed(a_f) < $signed(b_f);
          eq     <= a_f == b_f;
        end else begin
          result <= sum | pat;
          lt     <= 1'b0;
          eq     <= 1'b0;
        end
      end
    end
  end
endmodule

module tagged_alu_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   opcode,
  input logic [5:0]   tag_spec,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         lt,
  input logic         eq,
  input logic         skip
);
  logic [W-1:0] msk, pt;
  logic         a_good, b_good;

  always_comb begin
    case (tag_spec[5:4])
      2'd0:    msk = W'(1);
      2'd1:    msk = W'(3);
      2'd2:    msk = W'(7);
      default: msk = W'(15);
    endcase
  end
  assign pt     = W'(tag_spec[3:0]) & msk;
  assign a_good = (src_a & msk) == pt;
  assign b_good = (src_b & msk) == pt;

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_mismatch_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode != 2'b11 && !(a_good && b_good) |=> skip);
  p_cmp_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == 2'b10 && a_good && b_good |=> !skip);
  p_tag_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode != 2'b10 |=> skip || ((result & $past(msk)) == $past(pt)));
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(lt && eq));
endmodule

bind tagged_alu tagged_alu_chk #(.W(W), .IMM_W(IMM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .tag_spec(tag_spec), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
  .result(result), .lt(lt), .eq(eq), .skip(skip)
);

// File: tb/tagged_alu_tb_top.sv
module tagged_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          v;
    bit          cmp;
    bit          sk;
    logic [31:0] res;
    bit          lt;
    bit          eq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0]  opcode = '0;
  logic [5:0]  tag_spec = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic        out_valid, lt, eq, skip;
  logic [31:0] result;

  int   checks = 0, failures = 0;
  bit   done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_alu #(.W(32), .IMM_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .tag_spec(tag_spec), .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result), .lt(lt), .eq(eq), .skip(skip)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input bit v, input logic [1:0] op, input logic [5:0] ts,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [15:0] im, input string tag);
    exp_t e;
    int tw = int'(ts[5:4]) + 1;
    longint m = (longint'(1) << tw) - 1;
    longint pat = longint'(ts[3:0]) & m;
    longint av = longint'($signed(a)) >>> tw;
    longint bv = (op == 2'b11) ? longint'($signed(im)) : (longint'($signed(b)) >>> tw);
    longint s = (op == 2'b01) ? av - bv : av + bv;
    longint hi = (longint'(1) << (31 - tw)) - 1;
    bit ta = (longint'(a) & m) == pat;
    bit tb = (op == 2'b11) || ((longint'(b) & m) == pat);
    bit ov = (op != 2'b10) && (s > hi || s < -hi - 1);
    e.v   = v;
    e.cmp = (op == 2'b10);
    e.sk  = !ta || !tb || ov;
    e.res = 32'((s << tw) | pat);
    e.lt  = av < bv;
    e.eq  = av == bv;
    e.tag = tag;
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(out_valid == e.v, "R9", "out_valid", 32'(out_valid), 32'(e.v));
    if (e.v && out_valid) begin
      chk(skip == e.sk, e.tag, "skip", 32'(skip), 32'(e.sk));
      if (!e.sk && !e.cmp)
        chk(result == e.res, e.tag, "result", result, e.res);
      if (!e.sk && e.cmp) begin
        chk(lt == e.lt, e.tag, "lt", 32'(lt), 32'(e.lt));
        chk(eq == e.eq, e.tag, "eq", 32'(eq), 32'(e.eq));
      end
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [5:0] ts,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input string tag);
    @(negedge clk);
    compare_front();
    in_valid = v; opcode = op; tag_spec = ts; src_a = a; src_b = b; imm = im;
    q.push_back(model(v, op, ts, a, b, im, tag));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    // R1, R2: one-bit tag, pattern bits above bit 0 ignored
    step(1, 2'b00, 6'b00_1111, 32'h0000_0005, 32'h0000_0007, 16'h0, "R2");
    step(1, 2'b00, 6'b00_1110, 32'h0000_0004, 32'h0000_0006, 16'h0, "R1");
    // R3: tag mismatch on B only, then on A only
    step(1, 2'b00, 6'b01_0001, 32'h0000_0005, 32'h0000_0006, 16'h0, "R3");
    step(1, 2'b01, 6'b01_0001, 32'h0000_0007, 32'h0000_0005, 16'h0, "R3");
    // R4: add overflow at positive limit, subtract overflow at negative limit
    step(1, 2'b00, 6'b01_0001, 32'h7FFF_FFFD, 32'h0000_0005, 16'h0, "R4");
    step(1, 2'b01, 6'b01_0001, 32'h8000_0001, 32'h0000_0005, 16'h0, "R4");
    // R3, R4 together: mismatch and overflow in the same operation
    step(1, 2'b00, 6'b01_0001, 32'h7FFF_FFFE, 32'h0000_0005, 16'h0, "R4");
    // R6: largest sum that fits
    step(1, 2'b00, 6'b01_0001, 32'h7FFF_FFF9, 32'h0000_0005, 16'h0, "R6");
    // R5, R8: compare with extreme magnitudes, then equal operands, then mismatch
    step(1, 2'b10, 6'b01_0001, 32'h7FFF_FFFD, 32'h8000_0001, 16'h0, "R5");
    step(1, 2'b10, 6'b10_0011, 32'h8000_0003, 32'h8000_0003, 16'h0, "R8");
    step(1, 2'b10, 6'b10_0011, 32'h8000_0003, 32'h0000_0004, 16'h0, "R5");
    // R7: add-immediate, negative immediate, B carries a wrong tag
    step(1, 2'b11, 6'b11_1010, 32'h0000_00AA, 32'h0000_000F, 16'hFFFD, "R7");
    step(1, 2'b11, 6'b11_1010, 32'h7FFF_FFFA, 32'h0000_0000, 16'h0001, "R7");
    // R9: idle cycle, R10: every opcode via random traffic
    step(0, 2'b00, 6'b00_0000, 32'h0, 32'h0, 16'h0, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  ts = 6'($urandom);
      logic [31:0] a = $urandom, b = $urandom;
      logic [3:0]  tm = 4'((1 << (int'(ts[5:4]) + 1)) - 1);
      if (($urandom % 8) == 0) a = {1'b0, {31{1'b1}}} ^ (32'($urandom) & 32'h3F);
      if (($urandom % 8) == 0) b = 32'h8000_0000 | (32'($urandom) & 32'h3F);
      if (($urandom % 4) != 0) a = (a & ~32'(tm)) | 32'(ts[3:0] & tm);
      if (($urandom % 4) != 0) b = (b & ~32'(tm)) | 32'(ts[3:0] & tm);
      step(($urandom % 5) != 0, 2'($urandom), ts, a, b, 16'($urandom), "R10");
    end
    step(0, 2'b00, 6'b0, 32'h0, 32'h0, 16'h0, "R9");
    @(negedge clk);
    compare_front();
    finish_run();
  end
endmodule